// File: doc/BRIEF.md
# SPI Transmit Data Queue

This block sits between a bus-side register interface and a serial shift engine and holds the outgoing words until the shifter can take them. It has two operating modes. In single-buffer mode there is one holding slot. A write is only taken after software has read the status and seen the empty flag set, which is the usual read-then-write handshake of a simple serial port. In queue mode the same storage works as an eight-byte first-in first-out queue. The queue holds eight 8-bit entries or four 16-bit entries, and any write is accepted while there is room.

The shifter is modelled as a handshake. The block raises `ld_valid_o` with the head word on `ld_data_o` for one cycle. The shifter takes the word at that clock edge and pulses `sh_done_i` when it has finished shifting it out. A waiting word is handed over in the same cycle as the completion pulse. The flags report empty, full and a nearly-empty level, and the nearly-empty threshold can be selected.

Top module: `spi_tx_queue`

## Requirements
- R1: After reset the queue is empty, `empty_o`=1, `full_o`=0 and no load is requested.
- R2: In single-buffer mode (`fifo_mode_i`=0) a write is taken only if `stat_rd_i` was high with `empty_o`=1 in an earlier cycle since the last accepted write. Any other write is ignored, and `empty_o` stays 1.
- R3: In single-buffer mode an accepted write stores the word and clears `empty_o` on the next clock edge.
- R4: With the shifter idle, a word stored at edge k is offered on `ld_valid_o`/`ld_data_o` during the following cycle and taken at edge k+1. `empty_o` is set again after that edge if nothing else waits.
- R5: While the shifter is busy, a waiting word is offered in the cycle where `sh_done_i` is high. A completion with nothing waiting produces no load, and `empty_o` stays 1.
- R6: In queue mode (`fifo_mode_i`=1) any write clears `empty_o` without a status read. `empty_o` sets only after the last queued entry has been loaded.
- R7: Entries are loaded in write order. With `wide_i`=0, `ld_data_o[15:8]` is 0 and `ld_data_o[7:0]` equals the written low byte. With `wide_i`=1 all 16 bits are passed.
- R8: In queue mode `full_o` is 1 exactly when 8 bytes are held: 8 entries with `wide_i`=0, or 4 entries with `wide_i`=1.
- R9: A write while the queue is full is discarded, even if a load happens in the same cycle. The entries already queued are not changed.
- R10: In queue mode `nearly_empty_o` is 1 when the bytes held (entries times 2 if `wide_i`=1, otherwise entries) are at most 2 with `wmark_sel_i`=0, or at most 4 with `wmark_sel_i`=1. This includes the empty case.
- R11: In single-buffer mode `full_o` and `nearly_empty_o` are held at 0.
- R12: A write and a load in the same cycle on a queue that is neither full nor empty both take effect, and the entry count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_mode_i | input | 1 | 1 selects queue mode, 0 selects single-buffer mode |
| wide_i | input | 1 | 1 selects 16-bit entries, 0 selects 8-bit entries |
| wmark_sel_i | input | 1 | Nearly-empty threshold: 0 is 2 bytes, 1 is 4 bytes |
| stat_rd_i | input | 1 | Status read strobe |
| wr_en_i | input | 1 | Data register write strobe |
| wr_data_i | input | 16 | Write data |
| sh_done_i | input | 1 | Shifter finished its current word |
| ld_valid_o | output | 1 | Load request; the shifter takes the word at this edge |
| ld_data_o | output | 16 | Word offered to the shifter |
| empty_o | output | 1 | Nothing is waiting to be loaded |
| nearly_empty_o | output | 1 | Level is at or below the selected threshold |
| full_o | output | 1 | Eight bytes are held |

## Verification
A bus write and a shifter hand-over can land in the same cycle. In that cycle one entry is pushed and one is popped. The bench provokes this in two cases: with `sh_done_i` raised together with a write on a partly filled 16-bit queue, and together with a write on a full queue. It then judges the result in two ways. The flags after the edge must show the level unchanged in the first case and dropped by one in the second. A scoreboard compares every later load against the expected order, so it catches any word that was lost, duplicated or wrongly accepted.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;
  typedef enum logic {
    TXQ_BUF  = 1'b0,
    TXQ_FIFO = 1'b1
  } txq_mode_e;

  // bytes held for a given entry count and entry width
  function automatic int unsigned txq_bytes(int unsigned entries, logic wide);
    return wide ? entries * 2 : entries;
  endfunction
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int unsigned DW      = 16,
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned PTR_W  = $clog2(ENTRIES),
  localparam int unsigned CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    head_o,
  output logic [CNT_W-1:0] count_o
);
  logic [DW-1:0]    mem_q [ENTRIES];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
    return (p == PTR_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (count_q < CNT_W'(ENTRIES)));
  // R5
  pop_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (count_q != '0));
  // R8
  count_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(ENTRIES));
endmodule

// File: rtl/txq_arm.sv
module txq_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fifo_i,
  input  logic stat_rd_i,
  input  logic empty_i,
  input  logic wr_en_i,
  output logic accept_o
);
  logic armed_q;

  assign accept_o = wr_en_i && (fifo_i || armed_q);

  // a taken write consumes the arming; a new status read is needed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  armed_q <= 1'b0;
    else if (fifo_i)              armed_q <= 1'b0;
    else if (accept_o)            armed_q <= 1'b0;
    else if (stat_rd_i && empty_i) armed_q <= 1'b1;
  end
endmodule

// File: rtl/txq_shift.sv
module txq_shift (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic avail_i,
  input  logic done_i,
  output logic load_o
);
  logic busy_q;

  assign load_o = avail_i && (!busy_q || done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_q <= 1'b0;
    else if (load_o) busy_q <= 1'b1;
    else if (done_i) busy_q <= 1'b0;
  end
endmodule

// File: rtl/txq_flags.sv
module txq_flags
  import spi_txq_pkg::*;
#(
  parameter int unsigned DEPTH_BYTES = 8,
  parameter int unsigned NE_LO_BYTES = 2,
  parameter int unsigned NE_HI_BYTES = 4,
  localparam int unsigned CNT_W      = $clog2(DEPTH_BYTES + 1)
) (
  input  logic             fifo_i,
  input  logic             wide_i,
  input  logic             sel_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             empty_o,
  output logic             nearly_o,
  output logic             full_o
);
  int unsigned bytes;
  int unsigned thr;

  always_comb begin
    bytes    = txq_bytes(32'(count_i), wide_i);
    thr      = sel_i ? NE_HI_BYTES : NE_LO_BYTES;
    empty_o  = (count_i == '0);
    full_o   = fifo_i && (bytes == DEPTH_BYTES);
    nearly_o = fifo_i && (bytes <= thr);
  end
endmodule

// File: rtl/spi_tx_queue.sv
module spi_tx_queue
  import spi_txq_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned DEPTH_BYTES = 8,
  parameter int unsigned NE_LO_BYTES = 2,
  parameter int unsigned NE_HI_BYTES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_mode_i,
  input  logic          wide_i,
  input  logic          wmark_sel_i,
  input  logic          stat_rd_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          sh_done_i,
  output logic          ld_valid_o,
  output logic [DW-1:0] ld_data_o,
  output logic          empty_o,
  output logic          nearly_empty_o,
  output logic          full_o
);
  localparam int unsigned ENTRIES = DEPTH_BYTES;
  localparam int unsigned WIDE_N  = DEPTH_BYTES / 2;
  localparam int unsigned CNT_W   = $clog2(ENTRIES + 1);
  localparam int unsigned HALF    = DW / 2;

  txq_mode_e        mode;
  logic [CNT_W-1:0] count, cap;
  logic [DW-1:0]    head;
  logic             accept, push, load;

  assign mode = txq_mode_e'(fifo_mode_i);

  always_comb begin
    if (mode == TXQ_FIFO) cap = wide_i ? CNT_W'(WIDE_N) : CNT_W'(ENTRIES);
    else                  cap = CNT_W'(1);
  end

  assign push = accept && (count < cap);

  txq_arm i_arm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fifo_i    (fifo_mode_i),
    .stat_rd_i (stat_rd_i),
    .empty_i   (empty_o),
    .wr_en_i   (wr_en_i),
    .accept_o  (accept)
  );

  txq_store #(.DW(DW), .ENTRIES(ENTRIES)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (load),
    .wdata_i (wr_data_i),
    .head_o  (head),
    .count_o (count)
  );

  txq_shift i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .avail_i (!empty_o),
    .done_i  (sh_done_i),
    .load_o  (load)
  );

  txq_flags #(
    .DEPTH_BYTES (DEPTH_BYTES),
    .NE_LO_BYTES (NE_LO_BYTES),
    .NE_HI_BYTES (NE_HI_BYTES)
  ) i_flags (
    .fifo_i   (fifo_mode_i),
    .wide_i   (wide_i),
    .sel_i    (wmark_sel_i),
    .count_i  (count),
    .empty_o  (empty_o),
    .nearly_o (nearly_empty_o),
    .full_o   (full_o)
  );

  assign ld_valid_o = load;
  assign ld_data_o  = wide_i ? head : {{(DW-HALF){1'b0}}, head[HALF-1:0]};

  // R11
  buf_flags_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_mode_i |-> (!full_o && !nearly_empty_o));
  // R2
  buf_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_mode_i |-> (count <= CNT_W'(1)));
  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !wr_en_i) |=> empty_o);
  // R4
  load_has_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |-> !empty_o);
endmodule

// File: tb/test_spi_tx_queue.sv
module test_spi_tx_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_mode = 1'b0, wide = 1'b1, wsel = 1'b0;
  logic        stat_rd = 1'b0, wr_en = 1'b0, sh_done = 1'b0;
  logic [15:0] wr_data = '0;
  logic        ld_valid, empty, nearly, full;
  logic [15:0] ld_data;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];

  always #5 clk = ~clk;

  spi_tx_queue i_spi_tx_queue (
    .clk_i(clk), .rst_ni(rst_n), .fifo_mode_i(fifo_mode), .wide_i(wide),
    .wmark_sel_i(wsel), .stat_rd_i(stat_rd), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .sh_done_i(sh_done), .ld_valid_o(ld_valid), .ld_data_o(ld_data),
    .empty_o(empty), .nearly_empty_o(nearly), .full_o(full)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle of stimulus; called and returns at posedge+1
  task automatic apply(input logic wr, input logic [15:0] d, input logic rd, input logic done);
    wr_en = wr; wr_data = d; stat_rd = rd; sh_done = done;
    @(posedge clk); #1;
    wr_en = 1'b0; stat_rd = 1'b0; sh_done = 1'b0;
  endtask

  // driver: writes a word and records it in the scoreboard if it must be taken
  task automatic put(input logic [15:0] d, input logic ok, input logic done);
    if (ok) exp_q.push_back(wide ? d : {8'h00, d[7:0]});
    apply(1'b1, d, 1'b0, done);
  endtask

  // monitor: every load is matched against the scoreboard (R7)
  always @(negedge clk) begin
    if (rst_n && ld_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7: unexpected load actual=%0h expected=none", ld_data);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if (ld_data !== e) begin
          errors++;
          $display("FAIL R7: load data actual=%0h expected=%0h", ld_data, e);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check("R1 empty", empty, 1);
    check("R1 full", full, 0);
    check("R1 load", ld_valid, 0);
    check("R11 nearly", nearly, 0);

    // R2 write without status read is dropped
    put(16'hDEAD, 1'b0, 1'b0);
    check("R2 empty", empty, 1);

    // R3/R4 read, then write, idle shifter
    apply(1'b0, 16'h0, 1'b1, 1'b0);
    put(16'hA5A5, 1'b1, 1'b0);
    check("R3 empty", empty, 0);
    check("R4 ld_valid", ld_valid, 1);
    check("R11 full", full, 0);
    apply(1'b0, 16'h0, 1'b0, 1'b0);
    check("R4 empty", empty, 1);

    // R5 second word waits for the shifter
    apply(1'b0, 16'h0, 1'b1, 1'b0);
    put(16'h1234, 1'b1, 1'b0);
    check("R5 wait", ld_valid, 0);
    apply(1'b0, 16'h0, 1'b0, 1'b0);
    check("R5 still", ld_valid, 0);
    apply(1'b0, 16'h0, 1'b0, 1'b1);
    check("R5 empty", empty, 1);
    apply(1'b0, 16'h0, 1'b0, 1'b1);
    check("R5 no load", empty, 1);
    put(16'hBEEF, 1'b0, 1'b0);
    check("R2 rearm", empty, 1);

    // queue mode, 8-bit entries
    fifo_mode = 1'b1; wide = 1'b0; wsel = 1'b0; #1;
    check("R10 empty", nearly, 1);
    put(16'h5A11, 1'b1, 1'b0);
    check("R6 write", empty, 0);
    apply(1'b0, 16'h0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) put(16'(16'h5A30 + i), 1'b1, 1'b0);
    check("R8 full8", full, 1);
    check("R10 high", nearly, 0);
    put(16'h5AFF, 1'b0, 1'b0);
    check("R9 full", full, 1);
    for (int i = 0; i < 8; i++) begin
      int rem;
      apply(1'b0, 16'h0, 1'b0, 1'b1);
      rem = 7 - i;
      check("R10 level", nearly, (rem <= 2) ? 1 : 0);
      check("R6 level", empty, (rem == 0) ? 1 : 0);
    end
    apply(1'b0, 16'h0, 1'b0, 1'b1);

    // queue mode, 16-bit entries, 4-byte threshold
    wide = 1'b1; wsel = 1'b1;
    put(16'h1001, 1'b1, 1'b0);
    apply(1'b0, 16'h0, 1'b0, 1'b0);
    put(16'h2002, 1'b1, 1'b0);
    put(16'h3003, 1'b1, 1'b0);
    put(16'h4004, 1'b1, 1'b0);
    put(16'h5005, 1'b1, 1'b0);
    check("R8 full16", full, 1);
    put(16'h6006, 1'b0, 1'b1);
    check("R9 drop", full, 0);
    check("R10 six", nearly, 0);
    apply(1'b0, 16'h0, 1'b0, 1'b1);
    check("R10 four", nearly, 1);
    wsel = 1'b0; #1;
    check("R10 sel0", nearly, 0);
    wsel = 1'b1;
    put(16'h7007, 1'b1, 1'b1);
    check("R12 empty", empty, 0);
    check("R12 level", nearly, 1);
    check("R12 full", full, 0);
    apply(1'b0, 16'h0, 1'b0, 1'b1);
    check("R10 two", nearly, 1);
    apply(1'b0, 16'h0, 1'b0, 1'b1);
    check("R6 drained", empty, 1);
    apply(1'b0, 16'h0, 1'b0, 1'b1);
    check("R7 all loaded", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule